// File: doc/BRIEF.md
# Serial Command Responder

This block sits between a UART receiver and a UART transmitter and answers each receive event with a fixed four-byte ASCII reply. A received byte is sorted into one of three classes: upper-case `T`, lower-case `t`, or anything else. A receive error is sorted by its type: framing, parity or overrun. Every reply is two letters followed by carriage return (0x0D) and line feed (0x0A).

The reply leaves the block as a byte stream with a valid/ready handshake, so a transmitter can take bytes at its own pace. While a reply is in flight, the block drops every new receive event. When an error event is taken, the block raises a one-cycle clear toward the receiver. The data byte that arrived with that error is thrown away. Baud generation and bit serialisation are handled outside this block.

Top module: `uart_cmd_responder`

## Requirements
- R1: After reset, `tx_valid`, `err_clear` and `reply_done` are all 0.
- R2: When idle, a data event with byte 0x54 produces the reply 0x4F 0x4B 0x0D 0x0A.
- R3: When idle, a data event with byte 0x74 produces the reply 0x6F 0x6B 0x0D 0x0A.
- R4: When idle, a data event with any other byte produces the reply 0x55 0x43 0x0D 0x0A.
- R5: When idle, an error event produces one of three replies. A framing error gives 0x46 0x45 0x0D 0x0A. A parity error gives 0x50 0x45 0x0D 0x0A. An overrun error gives 0x4F 0x45 0x0D 0x0A.
- R6: When several error flags are set together, only one is answered. Framing is chosen over parity, and parity over overrun.
- R7: `err_clear` is 1 in exactly the cycle an error event is taken (idle, `err_valid` high, at least one flag set), and 0 otherwise. The data byte of that cycle is discarded.
- R8: From the cycle a reply starts until its fourth byte is accepted, data events and error events are ignored. No further reply and no `err_clear` follow from them.
- R9: If an error event and a data event arrive in the same idle cycle, the error reply is sent.
- R10: `reply_done` is 1 exactly in the cycle the fourth reply byte is accepted (`tx_valid` and `tx_ready` both high).
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value in the next cycle.
- R12: An `err_valid` strobe with no error flag set is not treated as an error event. If `rx_valid` is also high, that cycle is taken as a data event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` is a new byte |
| err_valid | input | 1 | One-cycle strobe: the error flags are valid |
| err_frame | input | 1 | Framing error flag |
| err_parity | input | 1 | Parity error flag |
| err_overrun | input | 1 | Overrun error flag |
| tx_data | output | 8 | Reply byte toward the transmitter |
| tx_valid | output | 1 | `tx_data` holds a reply byte |
| tx_ready | input | 1 | Transmitter accepts `tx_data` |
| err_clear | output | 1 | One-cycle pulse that clears the receiver's error flags |
| reply_done | output | 1 | Fourth reply byte accepted |

## Verification
Several internal faults show at the ports within the next reply:

- A wrong latched letter pair shows in the first or second byte.
- A wrong byte index shows as a missing or repeated CR/LF, or as `reply_done` on the wrong handshake.
- A busy flag that clears too early lets a second reply or a stray `err_clear` appear in the cycle after the fourth handshake.
- A busy flag that never clears keeps `tx_valid` high past that cycle.

Random backpressure on `tx_ready` shows, within one cycle, any byte that changes while it is stalled.

// File: rtl/uart_cmd_responder.sv
module uart_cmd_responder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          err_valid,
  input  logic          err_frame,
  input  logic          err_parity,
  input  logic          err_overrun,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          err_clear,
  output logic          reply_done
);
  localparam int NB = 4;
  localparam int IW = $clog2(NB);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  logic          busy;
  logic [IW-1:0] idx;
  logic [DW-1:0] hi_q, lo_q, hi_d, lo_d;

  wire err_hit  = err_valid & (err_frame | err_parity | err_overrun);
  wire take_err = ~busy & err_hit;
  wire take_rx  = ~busy & ~err_hit & rx_valid;
  wire hand     = busy & tx_ready;

  assign tx_valid   = busy;
  assign err_clear  = take_err;
  assign reply_done = hand & (idx == LAST);

  always_comb begin
    if (take_err) begin
      lo_d = DW'(8'h45);
      if (err_frame)       hi_d = DW'(8'h46);
      else if (err_parity) hi_d = DW'(8'h50);
      else                 hi_d = DW'(8'h4F);
    end else if (rx_data == DW'(8'h54)) begin
      hi_d = DW'(8'h4F); lo_d = DW'(8'h4B);
    end else if (rx_data == DW'(8'h74)) begin
      hi_d = DW'(8'h6F); lo_d = DW'(8'h6B);
    end else begin
      hi_d = DW'(8'h55); lo_d = DW'(8'h43);
    end
  end

  always_comb begin
    case (idx)
      IW'(0):  tx_data = hi_q;
      IW'(1):  tx_data = lo_q;
      IW'(2):  tx_data = DW'(8'h0D);
      default: tx_data = DW'(8'h0A);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      hi_q <= '0;
      lo_q <= '0;
    end else if (take_err || take_rx) begin
      busy <= 1'b1;
      idx  <= '0;
      hi_q <= hi_d;
      lo_q <= lo_d;
    end else if (hand) begin
      idx <= idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_cmd_responder_chk.sv
module uart_cmd_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       err_clear,
  input logic       reply_done,
  input logic       err_frame
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11
  AST_CLEAR_STARTS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> tx_valid && (tx_data == 8'h46 || tx_data == 8'h50 || tx_data == 8'h4F)); // R7
  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear && err_frame |=> tx_data == 8'h46); // R6
  AST_DONE_ON_LF: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |-> tx_valid && tx_ready && tx_data == 8'h0A); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |=> !tx_valid); // R8
endmodule

bind uart_cmd_responder uart_cmd_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .err_clear(err_clear), .reply_done(reply_done),
  .err_frame(err_frame)
);

// File: tb/sim_uart_cmd_responder.sv
module sim_uart_cmd_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, err_valid = 1'b0;
  logic err_frame = 1'b0, err_parity = 1'b0, err_overrun = 1'b0;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid, err_clear, reply_done;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  uart_cmd_responder u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pair(bit rv, logic [7:0] b, bit ev, bit f, bit p, bit o);
    if (ev && (f || p || o)) begin
      if (f) return 16'h4645;
      if (p) return 16'h5045;
      return 16'h4F45;
    end
    if (!rv) return 16'h0000;
    if (b == 8'h54) return 16'h4F4B;
    if (b == 8'h74) return 16'h6F6B;
    return 16'h5543;
  endfunction

  task automatic run_event(input bit rv, input logic [7:0] b, input bit ev,
                           input bit f, input bit p, input bit o, input string req);
    logic [15:0] pr;
    logic [7:0] exp_b [4];
    int got, guard;
    logic [7:0] prev_d;
    bit prev_stall;
    pr = exp_pair(rv, b, ev, f, p, o);
    exp_b[0] = pr[15:8]; exp_b[1] = pr[7:0]; exp_b[2] = 8'h0D; exp_b[3] = 8'h0A;
    @(negedge clk);
    rx_valid = rv; rx_data = b; err_valid = ev;
    err_frame = f; err_parity = p; err_overrun = o; tx_ready = 1'b0;
    #1;
    chk(err_clear == (ev && (f || p || o)), {req, "/R7 err_clear"}, err_clear, ev && (f || p || o));
    @(negedge clk);
    rx_valid = 0; err_valid = 0; err_frame = 0; err_parity = 0; err_overrun = 0;
    if (pr == 16'h0) begin
      #1;
      chk(!tx_valid && !err_clear, {req, "/R12 no reply"}, tx_valid, 0);
      return;
    end
    got = 0; guard = 0; prev_stall = 0; prev_d = '0;
    while (got < 4 && guard < 60) begin
      tx_ready = ($urandom_range(0, 2) != 0);
      rx_valid = $urandom_range(0, 1); rx_data = 8'($urandom);
      err_valid = $urandom_range(0, 1);
      err_frame = $urandom_range(0, 1); err_parity = $urandom_range(0, 1);
      err_overrun = $urandom_range(0, 1);
      #1;
      if (prev_stall) chk(tx_valid && tx_data == prev_d, "R11 hold", tx_data, prev_d);
      chk(!err_clear, "R8 clear while busy", err_clear, 0);
      if (tx_valid && tx_ready) begin
        chk(tx_data == exp_b[got], req, tx_data, exp_b[got]);
        chk(reply_done == (got == 3), "R10 done", reply_done, got == 3);
        got++;
      end else begin
        chk(tx_valid && !reply_done, "R11 valid held", tx_valid, 1);
      end
      prev_stall = tx_valid && !tx_ready;
      prev_d = tx_data;
      guard++;
      @(negedge clk);
    end
    if (got < 4) chk(0, {req, " timeout"}, got, 4);
    rx_valid = 0; err_valid = 0; err_frame = 0; err_parity = 0; err_overrun = 0;
    tx_ready = 0;
    #1;
    chk(!tx_valid && !err_clear, "R8 ignored during reply", tx_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && !err_clear && !reply_done, "R1 reset", tx_valid, 0);
    rst_n = 1'b1;
    run_event(1, 8'h54, 0, 0, 0, 0, "R2 T");
    run_event(1, 8'h74, 0, 0, 0, 0, "R3 t");
    run_event(1, 8'h41, 0, 0, 0, 0, "R4 other");
    run_event(1, 8'h55, 0, 0, 0, 0, "R4 near T");
    run_event(0, 8'h54, 1, 1, 0, 0, "R5 frame");
    run_event(0, 8'h00, 1, 0, 1, 0, "R5 parity");
    run_event(0, 8'h00, 1, 0, 0, 1, "R5 overrun");
    run_event(0, 8'h00, 1, 1, 1, 1, "R6 all");
    run_event(0, 8'h00, 1, 0, 1, 1, "R6 par+ovr");
    run_event(1, 8'h54, 1, 0, 0, 1, "R9 err+data");
    run_event(1, 8'h74, 1, 0, 0, 0, "R12 no flags");
    run_event(0, 8'h00, 1, 0, 0, 0, "R12 empty err");
    for (int i = 0; i < 60; i++) begin
      logic [7:0] b;
      b = ($urandom_range(0, 3) == 0) ? 8'h54 : ($urandom_range(0, 2) == 0) ? 8'h74 : 8'($urandom);
      run_event($urandom_range(0, 1), b, $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1), "R4 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule